// File: doc/BRIEF.md
# Banked GPIO Controller with Half-Word Masked Writes

This block is a memory-mapped general-purpose I/O peripheral that serves 118 pins split into four banks of 32, 22, 32 and 32 pins. A simple 32-bit register bus carries the traffic. It has a byte address, a write strobe, write data and a combinational read-data return. For every bank the block keeps an output value per pin, a direction bit per pin and an output-enable bit per pin. It drives the pad output values and the pad drive enables from these registers.

Software updates output values through two write-only registers per bank. One covers the lower sixteen pins of the bank and the other covers the upper sixteen. Each word carries an active-low bit mask in its top half and the data in its bottom half, so any subset of pins changes in a single bus write with no read-modify-write. Pin input levels pass through a two-stage synchronizer and can be read per bank from a read-only register. Bank 0 pins 7 and 8 are output-only.

Top module: `gpio_multibank`

## Requirements
- R1: Pins are numbered globally and consecutively by bank. Bank 0 is pins 0–31, bank 1 is pins 32–53, bank 2 is pins 54–85 and bank 3 is pins 86–117. Bank pin k of bank n is bit (first pin of n)+k of `pin_out`, `pin_oe` and `pin_in`.
- R2: A write to byte offset 8·n updates pins 0–15 of bank n. Word bit i+16 is the mask and word bit i is the data for bank pin i. The data bit is applied only where the mask bit is 0.
- R3: A write to byte offset 8·n+4 updates pins 16–31 of bank n. Word bit i+16 is the mask and word bit i is the data for bank pin 16+i, and the same active-low mask rule applies.
- R4: In a masked write, every output whose mask bit is 1 keeps its previous value.
- R5: The read-only register at 0x060+4·n returns, in bit k, the level of bank pin k. A level present on `pin_in` before clock edge e appears in the read data after edge e+1 (two synchronizer stages).
- R6: The direction register at 0x204+0x40·n is readable and writable. Bit k = 1 makes bank pin k an output.
- R7: The output-enable register at 0x208+0x40·n is readable and writable. `pin_oe` of a pin is 1 only when both its direction bit and its output-enable bit are 1.
- R8: The direction bits of bank 0 pins 7 and 8 always read 1. Writes of 0 to them are ignored.
- R9: Bits 22–31 of bank 1's direction and output-enable registers read 0, and writes to them are ignored. A high-half masked write to bank 1 changes only bank pins 16–21, and leaves bank 2 unchanged.
- R10: After reset, every output value, every output-enable bit and every direction bit except those named in R8 is 0, so every `pin_oe` bit is 0.
- R11: Reads of the masked-write offsets and of any unmapped offset return 0. A write to an unmapped offset changes nothing.
- R12: A bus write sampled at a rising clock edge takes effect at that edge. Before that edge, the read data and the pins still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 118 | Pad input levels, asynchronous to `clk` |
| pin_out | output | 118 | Pad output values |
| pin_oe | output | 118 | Pad drive enables, 1 = drive |

## Verification
Most internal state is visible within one cycle. A wrong output-value bit shows on `pin_out` right after the write edge. A wrong direction or enable bit shows on `pin_oe` right after the write edge, and also on the next read of that register. A wrong synchronizer depth or a bank slice taken from the wrong place shows as read data that arrives one edge early or late, or in another bank's word. A mask bit handled with the wrong polarity, or applied to the wrong half, corrupts a neighbouring pin on the very next edge. The reference model catches this because it checks every pin on every cycle, not only the pins that were addressed.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;

  localparam int unsigned NBANK  = 4;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  typedef int unsigned pins_t [NBANK];

  // register offsets; the address of every kind of register depends on the bank index
  localparam int unsigned OFS_SET_LO   = 32'h000;
  localparam int unsigned OFS_SET_HI   = 32'h004;
  localparam int unsigned STRIDE_SET   = 32'h008;
  localparam int unsigned OFS_LEVEL    = 32'h060;
  localparam int unsigned STRIDE_LEVEL = 32'h004;
  localparam int unsigned OFS_DIR      = 32'h204;
  localparam int unsigned OFS_DRV      = 32'h208;
  localparam int unsigned STRIDE_CFG   = 32'h040;

  function automatic int unsigned pin_base(pins_t p, int unsigned bank);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < NBANK; i++) begin
      if (i < bank) s = s + p[i];
    end
    return s;
  endfunction

  function automatic int unsigned set_lo_addr(int unsigned bank);
    return OFS_SET_LO + STRIDE_SET * bank;
  endfunction

  function automatic int unsigned set_hi_addr(int unsigned bank);
    return OFS_SET_HI + STRIDE_SET * bank;
  endfunction

  function automatic int unsigned level_addr(int unsigned bank);
    return OFS_LEVEL + STRIDE_LEVEL * bank;
  endfunction

  function automatic int unsigned dir_addr(int unsigned bank);
    return OFS_DIR + STRIDE_CFG * bank;
  endfunction

  function automatic int unsigned drv_addr(int unsigned bank);
    return OFS_DRV + STRIDE_CFG * bank;
  endfunction

endpackage

// File: rtl/gpio_mb_rst_sync.sv
module gpio_mb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;

endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
  import gpio_mb_pkg::*;
#(
  parameter int unsigned      PINS      = 32,
  parameter logic [WORD_W-1:0] FORCE_OUT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_dir,
  input  logic              wr_drv,
  input  logic [WORD_W-1:0] wdata,
  output logic [PINS-1:0]   val_out,
  output logic [PINS-1:0]   pad_en,
  output logic [WORD_W-1:0] dir_word,
  output logic [WORD_W-1:0] drv_word
);

  localparam logic [PINS-1:0] FORCED = FORCE_OUT[PINS-1:0];

  logic [PINS-1:0] val_q, val_n;
  logic [PINS-1:0] dir_q, dir_n;
  logic [PINS-1:0] drv_q, drv_n;
  logic            val_en;

  // next-state: half-word masked update, mask active-low
  always_comb begin
    val_n = val_q;
    for (int i = 0; i < int'(PINS); i++) begin
      if ((i < int'(HALF_W)) ? wr_lo : wr_hi) begin
        if (!wdata[(i % HALF_W) + HALF_W]) val_n[i] = wdata[i % HALF_W];
      end
    end
  end

  always_comb begin
    val_en = wr_lo | wr_hi;
    dir_n  = wdata[PINS-1:0] | FORCED;
    drv_n  = wdata[PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= FORCED;
    else if (wr_dir) dir_q <= dir_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drv_q <= '0;
    else if (wr_drv) drv_q <= drv_n;
  end

  assign val_out  = val_q;
  assign pad_en   = dir_q & drv_q;
  assign dir_word = WORD_W'(dir_q);
  assign drv_word = WORD_W'(drv_q);

endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
  import gpio_mb_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 12,
  parameter pins_t             BANK_PINS      = '{32, 22, 32, 32},
  parameter logic [WORD_W-1:0] BANK0_FORCE_OUT = 32'h0000_0180,
  localparam int unsigned      TOTAL          = pin_base(BANK_PINS, NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [TOTAL-1:0]  pin_in,
  output logic [TOTAL-1:0]  pin_out,
  output logic [TOTAL-1:0]  pin_oe
);

  logic             rst_sync_n;
  logic [TOTAL-1:0] level_sync;
  logic [WORD_W-1:0] level_word [NBANK];
  logic [WORD_W-1:0] dir_word   [NBANK];
  logic [WORD_W-1:0] drv_word   [NBANK];
  logic [WORD_W-1:0] rdata_n;

  gpio_mb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_mb_sync #(.W(TOTAL)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (level_sync)
  );

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    localparam int unsigned BASE  = pin_base(BANK_PINS, b);
    localparam int unsigned W     = BANK_PINS[b];
    localparam logic [WORD_W-1:0] FORCE = (b == 0) ? BANK0_FORCE_OUT : '0;

    logic wr_lo, wr_hi, wr_dir, wr_drv;

    always_comb begin
      wr_lo  = bus_we && (bus_addr == ADDR_W'(set_lo_addr(b)));
      wr_hi  = bus_we && (bus_addr == ADDR_W'(set_hi_addr(b)));
      wr_dir = bus_we && (bus_addr == ADDR_W'(dir_addr(b)));
      wr_drv = bus_we && (bus_addr == ADDR_W'(drv_addr(b)));
    end

    gpio_mb_bank #(.PINS(W), .FORCE_OUT(FORCE)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wr_dir   (wr_dir),
      .wr_drv   (wr_drv),
      .wdata    (bus_wdata),
      .val_out  (pin_out[BASE +: W]),
      .pad_en   (pin_oe[BASE +: W]),
      .dir_word (dir_word[b]),
      .drv_word (drv_word[b])
    );

    assign level_word[b] = WORD_W'(level_sync[BASE +: W]);
  end

  // read decode: only level, direction and enable registers are readable
  always_comb begin
    rdata_n = '0;
    for (int unsigned b = 0; b < NBANK; b++) begin
      if (bus_addr == ADDR_W'(level_addr(b))) rdata_n = level_word[b];
      if (bus_addr == ADDR_W'(dir_addr(b)))   rdata_n = dir_word[b];
      if (bus_addr == ADDR_W'(drv_addr(b)))   rdata_n = drv_word[b];
    end
  end

  assign bus_rdata = rdata_n;

endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TOTAL  = 118
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [TOTAL-1:0]  pin_in,
  input logic [TOTAL-1:0]  pin_out,
  input logic [TOTAL-1:0]  pin_oe
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: unmasked low-half bits take the written data
  p_lo_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(32'h000)) |=>
      ((pin_out[15:0] & ~$past(bus_wdata[31:16])) ==
       ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16]))));

  // R4: masked low-half bits hold
  p_lo_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(32'h000)) |=>
      ((pin_out[15:0] & $past(bus_wdata[31:16])) ==
       ($past(pin_out[15:0]) & $past(bus_wdata[31:16]))));

  // R8: output-only pins always read as outputs
  p_forced_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(32'h204)) |-> (bus_rdata[8:7] == 2'b11));

  // R9: bits beyond bank 1 width read 0
  p_narrow_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(32'h244) || bus_addr == ADDR_W'(32'h248)) |->
      (bus_rdata[31:22] == 10'd0));

  // R7: a driving pin must read back as an output
  p_drive_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(32'h204)) |-> ((pin_oe[31:0] & ~bus_rdata) == 32'd0));

  // R11: write-only masked registers read 0
  p_wo_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < ADDR_W'(32'h020)) |-> (bus_rdata == 32'd0));

  // R5: two-stage input latency on bank 0
  p_level_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && bus_addr == ADDR_W'(32'h060)) |->
      (bus_rdata == $past(pin_in[31:0], 2)));

  // R12: a direction write is visible right after its edge
  p_dir_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(32'h204)) |=>
      (bus_addr != ADDR_W'(32'h204) || bus_rdata == ($past(bus_wdata) | 32'h180)));

endmodule

bind gpio_multibank gpio_multibank_chk #(.ADDR_W(ADDR_W), .TOTAL(TOTAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_multibank_tb_top.sv
module gpio_multibank_tb_top;

  localparam int NP = 118;

  logic          clk;
  logic          rst_n;
  logic [11:0]   bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bank layout from R1
  int bw [4] = '{32, 22, 32, 32};
  int bb [4] = '{0, 32, 54, 86};

  logic [NP-1:0] m_out, m_dir, m_oe, m_s1, m_s2;

  gpio_multibank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < bw[b]; i++) begin
        if (a == 12'(32'h060 + 4 * b))  r[i] = m_s2[bb[b] + i];
        if (a == 12'(32'h204 + 64 * b)) r[i] = m_dir[bb[b] + i];
        if (a == 12'(32'h208 + 64 * b)) r[i] = m_oe[bb[b] + i];
      end
    end
    return r;
  endfunction

  task automatic model_edge(input logic [11:0] a, input logic we, input logic [31:0] d);
    if (we) begin
      for (int b = 0; b < 4; b++) begin
        for (int i = 0; i < 16; i++) begin
          if (a == 12'(8 * b) && i < bw[b] && !d[16 + i])
            m_out[bb[b] + i] = d[i];
          if (a == 12'(8 * b + 4) && (i + 16) < bw[b] && !d[16 + i])
            m_out[bb[b] + 16 + i] = d[i];
        end
        for (int i = 0; i < bw[b]; i++) begin
          if (a == 12'(32'h204 + 64 * b))
            m_dir[bb[b] + i] = d[i] | (b == 0 && (i == 7 || i == 8));
          if (a == 12'(32'h208 + 64 * b))
            m_oe[bb[b] + i] = d[i];
        end
      end
    end
    m_s2 = m_s1;
    m_s1 = pin_in;
  endtask

  // one bus cycle: drive at negedge, check read before edge, check pins after edge
  task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d, input string tag);
    bus_addr  = a;
    bus_we    = we;
    bus_wdata = d;
    #1;
    chk(tag, 128'(bus_rdata), 128'(exp_read(a)));
    @(posedge clk);
    model_edge(a, we, d);
    @(negedge clk);
    chk("R2/R3/R4 pin_out", 128'(pin_out), 128'(m_out));
    chk("R7 pin_oe", 128'(pin_oe), 128'(m_dir & m_oe));
    bus_we = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    chk(tag, 128'(bus_rdata), 128'(exp));
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    m_out = '0; m_oe = '0; m_s1 = '0; m_s2 = '0;
    m_dir = '0; m_dir[7] = 1'b1; m_dir[8] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10 reset pin_oe", 128'(pin_oe), 128'd0);
    chk("R10 reset pin_out", 128'(pin_out), 128'd0);
    peek(12'h208, 32'h0, "R10 reset enable");
    peek(12'h204, 32'h0000_0180, "R8 reset direction");

    // R2 full low-half write, then R4 partial mask
    step(12'h000, 1'b1, 32'h0000_A5A5, "R11 read of write-only");
    chk("R2 low half", 128'(pin_out[15:0]), 128'h A5A5);
    step(12'h000, 1'b1, 32'hFF00_00FF, "R11");
    chk("R4 masked keep", 128'(pin_out[15:0]), 128'h A5FF);

    // R3 and R9 high half of bank 1
    step(12'h00C, 1'b1, 32'h0000_FFFF, "R11");
    chk("R9 bank1 hi pins", 128'(pin_out[53:48]), 128'h3F);
    chk("R9 bank2 untouched", 128'(pin_out[85:54]), 128'h0);
    chk("R3 bank1 lo untouched", 128'(pin_out[47:32]), 128'h0);

    // R1 bank 3 upper half, global pins 102 and 117
    step(12'h01C, 1'b1, 32'h7FFE_8001, "R11");
    chk("R1 pin 102", 128'(pin_out[102]), 128'h1);
    chk("R1 pin 117", 128'(pin_out[117]), 128'h1);

    // R8 forced direction, R9 narrow bank, R6 readback
    step(12'h204, 1'b1, 32'h0000_0000, "R8");
    peek(12'h204, 32'h0000_0180, "R8 zero write ignored");
    step(12'h244, 1'b1, 32'hFFFF_FFFF, "R9");
    peek(12'h244, 32'h003F_FFFF, "R9 dir width");
    step(12'h248, 1'b1, 32'hFFFF_FFFF, "R9");
    peek(12'h248, 32'h003F_FFFF, "R9 enable width");
    step(12'h284, 1'b1, 32'h1234_5678, "R6");
    peek(12'h284, 32'h1234_5678, "R6 dir readback");

    // R7 drive gating
    step(12'h204, 1'b1, 32'h0000_000F, "R6");
    step(12'h208, 1'b1, 32'hFFFF_FFFF, "R7");
    chk("R7 gated enable", 128'(pin_oe[31:0]), 128'h0000_018F);

    // R12 timing of a write
    step(12'h2C4, 1'b1, 32'h0000_FFFF, "R12 old value before edge");
    peek(12'h2C4, 32'h0000_FFFF, "R12 new value after edge");

    // R11 unmapped write/read
    step(12'h100, 1'b1, 32'hFFFF_FFFF, "R11 unmapped read");
    peek(12'h100, 32'h0, "R11 unmapped read");
    peek(12'h004, 32'h0, "R11 write-only read");

    // R5 two-stage input latency on bank 2
    pin_in[85:54] = 32'hDEAD_BEEF;
    step(12'h068, 1'b0, 32'h0, "R5 before first edge");
    step(12'h068, 1'b0, 32'h0, "R5 after one edge");
    peek(12'h068, 32'hDEAD_BEEF, "R5 after two edges");

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      int k, b;
      logic [11:0] a;
      k = int'($urandom % 7);
      b = int'($urandom % 4);
      case (k)
        0: a = 12'(8 * b);
        1: a = 12'(8 * b + 4);
        2: a = 12'(32'h060 + 4 * b);
        3: a = 12'(32'h204 + 64 * b);
        4: a = 12'(32'h208 + 64 * b);
        5: a = 12'(32'h300 + 4 * b);
        default: a = 12'(32'h020 + 4 * b);
      endcase
      if ((n % 3) == 0) pin_in = NP'({$urandom, $urandom, $urandom, $urandom});
      step(a, 1'($urandom % 2), $urandom, "R5/R6/R7/R11 read");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule